// File: doc/BRIEF.md
# Vector element extract unit

This unit pulls one unsigned byte, halfword or word out of a 128-bit vector operand and returns it zero-extended as a 64-bit scalar. The starting byte comes from the low four bits of a 64-bit index operand. A 3-bit operation select chooses the element size and the indexing direction. In left-indexed mode bytes are numbered from the most significant end of the vector. In right-indexed mode they are numbered from the least significant end.

Requests enter through a valid/ready port and results leave through a valid/ready port, one cycle after acceptance. The result stage is one register deep. `in_ready` is high whenever that register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result and its flags are held unchanged and no new request is taken.

Two plain control inputs travel with each request:
- A vector-unit enable. When it is low, the request turns into an unavailable-unit exception.
- An ISA-level select. It decides whether the two operation codes shared with word-merge operations mean extract or merge. The merge path itself lives elsewhere, so this unit only raises a flag for it.

Top module: `vec_extract_unit`

## Requirements
- R1: A request accepted on a clock edge (`in_valid` and `in_ready` high) gives `out_valid` high after that edge. `in_ready` is high when the result stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R2: Only bits 3:0 of `in_index` are used. Bits 63:4 have no effect on the result.
- R3: `in_op` encodes the minor operation code minus 24. Bit 2 selects right indexing when 1. Bits 1:0 select the size: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits. Codes 3 and 7 are reserved and give `out_wr`, `out_unavail` and `out_merge` all 0 with `out_data` 0.
- R4: In right-indexed mode, with size s and index i, the result is the low s bits of the vector shifted right by 8*i bit positions. Bits beyond vector bit 127 read as zero.
- R5: In left-indexed mode, bit 127 is the most significant bit of byte 0. The result is the low s bits of the vector shifted right by (16-i)*8-s bit positions.
- R6: In left-indexed mode, when (16-i)*8-s is negative, the vector is shifted left by the magnitude of that value instead, so the missing low bits of the result are zero.
- R7: Every result bit at or above position s is zero.
- R8: Codes 2 and 6 with `in_isa_new` low give `out_merge` 1, `out_wr` 0 and `out_data` 0. With `in_isa_new` high they extract. All other codes are unaffected by `in_isa_new`.
- R9: With `in_vec_en` low, any code gives `out_unavail` 1, `out_wr` 0, `out_merge` 0 and `out_data` 0.
- R10: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_index | input | 64 | Index operand; low 4 bits give the byte position |
| in_vec | input | 128 | Vector operand, bit 127 most significant |
| in_op | input | 3 | Operation select: direction and element size |
| in_isa_new | input | 1 | Selects extract meaning for the shared codes |
| in_vec_en | input | 1 | Vector unit enable |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result when high |
| out_data | output | 64 | Zero-extended element |
| out_wr | output | 1 | Result is to be written to the scalar destination |
| out_unavail | output | 1 | Vector-unavailable exception |
| out_merge | output | 1 | Request belongs to the merge path |

## Verification
The bench builds the unit with its default parameters: a 16-byte vector, elements of up to 4 bytes and a 64-bit result. With these values all 16 indices of every operation fit in a short sweep, including the left-indexed tails where a halfword or word runs past byte 15. A second sweep sets random upper index bits and toggles `out_ready` at random. That sweep covers the hold rule of the one-deep result stage and the accept-while-draining case.

// File: rtl/ext_pkg.sv
package ext_pkg;

  // Size field of the operation select (bits 1:0)
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } ext_size_e;

  // Bit of the operation select that picks right indexing
  localparam int OP_RIGHT_BIT = 2;

  typedef struct packed {
    logic wr;
    logic unavail;
    logic merge;
  } ext_flags_t;

endpackage

// File: rtl/ext_decode.sv
module ext_decode
  import ext_pkg::*;
#(
  parameter int NB_W = 3
) (
  input  logic [2:0]      op,
  input  logic            isa_new,
  input  logic            vec_en,
  output logic            right,
  output logic [NB_W-1:0] nbytes,
  output ext_flags_t      flags
);

  ext_size_e sz;
  logic      legal;
  logic      shared_code;
  logic      as_merge;

  always_comb begin
    sz = ext_size_e'(op[1:0]);
    right = op[OP_RIGHT_BIT];
    unique case (sz)
      SZ_BYTE: nbytes = NB_W'(1);
      SZ_HALF: nbytes = NB_W'(2);
      SZ_WORD: nbytes = NB_W'(4);
      default: nbytes = '0;
    endcase
  end

  assign legal       = (sz != SZ_RSVD);
  assign shared_code = (sz == SZ_WORD);
  assign as_merge    = shared_code && !isa_new;

  always_comb begin
    flags.unavail = !vec_en;
    flags.merge   = vec_en && as_merge;
    flags.wr      = vec_en && legal && !as_merge;
  end

endmodule

// File: rtl/ext_shift.sv
module ext_shift #(
  parameter int VEC_BYTES = 16,
  parameter int MAX_BYTES = 4,
  parameter int RES_W     = 64,
  parameter int IDX_W     = $clog2(VEC_BYTES),
  parameter int NB_W      = $clog2(MAX_BYTES) + 1
) (
  input  logic [VEC_BYTES*8-1:0] vec,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   right,
  input  logic [NB_W-1:0]        nbytes,
  output logic [RES_W-1:0]       field
);

  localparam int LANE_BITS = MAX_BYTES * 8;

  // Least-significant vector byte feeding result lane 0; negative when a
  // left-indexed field runs off the low end of the vector.
  int start;
  logic [7:0] lane [MAX_BYTES];

  always_comb begin
    if (right) start = int'(idx);
    else       start = VEC_BYTES - int'(idx) - int'(nbytes);
  end

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
    always_comb begin
      lane[k] = 8'h00;
      for (int b = 0; b < VEC_BYTES; b++) begin
        if ((k < int'(nbytes)) && (start + k == b)) lane[k] = vec[b*8 +: 8];
      end
    end
  end

  always_comb begin
    field = '0;
    for (int k = 0; k < MAX_BYTES; k++) field[k*8 +: 8] = lane[k];
  end

  if (RES_W < LANE_BITS) begin : g_bad_width
    initial $error("ext_shift: RES_W smaller than widest element");
  end

endmodule

// File: rtl/ext_outreg.sv
module ext_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         vld_q;
  logic [W-1:0] data_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

endmodule

// File: rtl/vec_extract_unit.sv
module vec_extract_unit
  import ext_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int MAX_BYTES = 4,
  parameter int INDEX_W   = 64,
  parameter int RES_W     = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [INDEX_W-1:0]     in_index,
  input  logic [VEC_BYTES*8-1:0] in_vec,
  input  logic [2:0]             in_op,
  input  logic                   in_isa_new,
  input  logic                   in_vec_en,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [RES_W-1:0]       out_data,
  output logic                   out_wr,
  output logic                   out_unavail,
  output logic                   out_merge
);

  localparam int IDX_W = $clog2(VEC_BYTES);
  localparam int NB_W  = $clog2(MAX_BYTES) + 1;
  localparam int FLG_W = $bits(ext_flags_t);
  localparam int PAY_W = FLG_W + RES_W;

  logic [IDX_W-1:0] idx;
  logic             unused_index_hi;
  logic             right;
  logic [NB_W-1:0]  nbytes;
  ext_flags_t       flags;
  logic [RES_W-1:0] field;
  logic [RES_W-1:0] result;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;
  ext_flags_t       flags_out;

  assign idx             = in_index[IDX_W-1:0];
  assign unused_index_hi = ^in_index[INDEX_W-1:IDX_W];

  ext_decode #(.NB_W(NB_W)) u_dec (
    .op      (in_op),
    .isa_new (in_isa_new),
    .vec_en  (in_vec_en),
    .right   (right),
    .nbytes  (nbytes),
    .flags   (flags)
  );

  ext_shift #(
    .VEC_BYTES (VEC_BYTES),
    .MAX_BYTES (MAX_BYTES),
    .RES_W     (RES_W),
    .IDX_W     (IDX_W),
    .NB_W      (NB_W)
  ) u_shift (
    .vec    (in_vec),
    .idx    (idx),
    .right  (right),
    .nbytes (nbytes),
    .field  (field)
  );

  assign result = flags.wr ? field : '0;
  assign pay_in = {flags, result};

  ext_outreg #(.W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign flags_out   = ext_flags_t'(pay_out[PAY_W-1:RES_W]);
  assign out_data    = pay_out[RES_W-1:0];
  assign out_wr      = flags_out.wr;
  assign out_unavail = flags_out.unavail;
  assign out_merge   = flags_out.merge;

endmodule

// File: rtl/ext_chk.sv
module ext_chk #(
  parameter int RES_W     = 64,
  parameter int MAX_BYTES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0] out_data,
  input logic             out_wr,
  input logic             out_unavail,
  input logic             out_merge
);

  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_wr) && $stable(out_unavail) && $stable(out_merge)));

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_wr, out_unavail, out_merge}));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[RES_W-1:MAX_BYTES*8] == '0));

  // R9
  no_write_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wr) |-> (out_data == '0));

endmodule

bind vec_extract_unit ext_chk #(.RES_W(RES_W), .MAX_BYTES(MAX_BYTES)) u_chk (.*);

// File: tb/sim_vec_extract_unit.sv
`timescale 1ns/1ps
module sim_vec_extract_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_index = '0;
  logic [127:0] in_vec = '0;
  logic [2:0]   in_op = '0;
  logic         in_isa_new = 1'b1;
  logic         in_vec_en = 1'b1;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [63:0]  out_data;
  logic         out_wr;
  logic         out_unavail;
  logic         out_merge;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit accepted;
  bit held = 1'b0;
  logic [66:0] held_val;

  logic [66:0] exp_q[$];
  string       tag_q[$];
  int          sz_q[$];

  always #2.5 clk = ~clk;

  vec_extract_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Behavioural reference: flags {wr,unavail,merge} then 64-bit data.
  function automatic logic [66:0] ref_model(input logic [2:0] op, input logic isa, input logic en,
      input logic [63:0] index, input logic [127:0] v, output string tag, output int size);
    int i;
    int sh;
    logic [63:0] r;
    i = int'(index[3:0]);
    size = (op[1:0] == 2'd0) ? 8 : (op[1:0] == 2'd1) ? 16 : 32;
    if (!en) begin
      tag = "R9"; size = 64; return {3'b010, 64'd0};
    end
    if (op[1:0] == 2'd3) begin
      tag = "R3"; size = 64; return 67'd0;
    end
    if (op[1:0] == 2'd2 && !isa) begin
      tag = "R8"; size = 64; return {3'b001, 64'd0};
    end
    if (op[2]) begin
      r = 64'(v >> (i * 8));
      tag = (index[63:4] != 0) ? "R2" : "R4";
    end else begin
      sh = (16 - i) * 8 - size;
      if (sh >= 0) begin
        r = 64'(v >> sh);
        tag = (index[63:4] != 0) ? "R2" : "R5";
      end else begin
        r = 64'(v << (-sh));
        tag = "R6";
      end
    end
    r = r & ((64'd1 << size) - 64'd1);
    return {3'b100, r};
  endfunction

  // One clock: drive at negedge, settle, then observe outputs and acceptance.
  task automatic step(input bit vld, input logic [2:0] op, input logic isa, input logic en,
      input logic [63:0] index, input logic [127:0] v, input bit rdy);
    logic [66:0] act;
    logic [66:0] e;
    string t;
    int s;
    @(negedge clk);
    in_valid = vld; in_op = op; in_isa_new = isa; in_vec_en = en;
    in_index = index; in_vec = v; out_ready = rdy;
    #1;
    act = {out_wr, out_unavail, out_merge, out_data};
    if (held) chk(out_valid && act == held_val, "R1 hold", act, held_val);
    held = out_valid && !out_ready;
    held_val = act;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected result", act, 67'd0);
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front(); s = sz_q.pop_front();
        chk(act == e, t, act, e);
        if (s < 64) chk((out_data >> s) == 64'd0, "R7", act, e);
      end
    end
    accepted = vld && in_ready;
    if (accepted) begin
      e = ref_model(op, isa, en, index, v, t, s);
      exp_q.push_back(e); tag_q.push_back(t); sz_q.push_back(s);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic isa, input logic en,
      input logic [63:0] index, input logic [127:0] v, input bit stall);
    do step(1'b1, op, isa, en, index, v, stall ? 1'($urandom % 2) : 1'b1);
    while (!accepted);
  endtask

  function automatic logic [127:0] rvec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (3) begin
      @(negedge clk); #1;
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R10",
          {65'd0, out_valid, in_ready}, 67'd1);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Sweep all codes and indices, upper index bits clear, no back-pressure.
    for (int op = 0; op < 8; op++) begin
      if (op == 3 || op == 7) continue;
      for (int i = 0; i < 16; i++) send(3'(op), 1'b1, 1'b1, 64'(i), rvec(), 1'b0);
    end

    // Sweep again with random upper index bits and random back-pressure (R2, R1).
    for (int op = 0; op < 8; op++) begin
      if (op == 3 || op == 7) continue;
      for (int i = 0; i < 16; i++)
        send(3'(op), 1'b1, 1'b1, {$urandom, 28'($urandom), 4'(i)}, rvec(), 1'b1);
    end

    // Reserved codes (R3).
    send(3'd3, 1'b1, 1'b1, 64'd5, rvec(), 1'b0);
    send(3'd7, 1'b1, 1'b1, 64'd9, rvec(), 1'b0);

    // Shared codes at the older ISA level merge (R8); others still extract.
    send(3'd2, 1'b0, 1'b1, 64'd0, rvec(), 1'b0);
    send(3'd6, 1'b0, 1'b1, 64'd4, rvec(), 1'b0);
    send(3'd0, 1'b0, 1'b1, 64'd3, rvec(), 1'b0);
    send(3'd5, 1'b0, 1'b1, 64'd14, rvec(), 1'b0);

    // Unit disabled (R9), including a shared and a reserved code.
    send(3'd0, 1'b1, 1'b0, 64'd1, rvec(), 1'b0);
    send(3'd2, 1'b0, 1'b0, 64'd7, rvec(), 1'b0);
    send(3'd7, 1'b1, 1'b0, 64'd2, rvec(), 1'b0);

    // Fixed-pattern left tails (R6): word at index 14 of a counting vector.
    send(3'd2, 1'b1, 1'b1, 64'd14, 128'h00112233445566778899AABBCCDDEEFF, 1'b0);
    send(3'd1, 1'b1, 1'b1, 64'd15, 128'h00112233445566778899AABBCCDDEEFF, 1'b0);

    // Long stall then drain (R1).
    send(3'd4, 1'b1, 1'b1, 64'd6, rvec(), 1'b0);
    repeat (4) step(1'b0, 3'd0, 1'b1, 1'b1, 64'd0, 128'd0, 1'b0);
    for (int k = 0; k < 8 && exp_q.size() != 0; k++)
      step(1'b0, 3'd0, 1'b1, 1'b1, 64'd0, 128'd0, 1'b1);
    chk(exp_q.size() == 0, "R1 drain", 67'(exp_q.size()), 67'd0);
    step(1'b0, 3'd0, 1'b1, 1'b1, 64'd0, 128'd0, 1'b1);
    chk(out_valid == 1'b0, "R1 idle", {66'd0, out_valid}, 67'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule